// File: doc/BRIEF.md
# Dibit-Commanded Interrupt Controller

This block keeps one sticky interrupt request and one enable mask for each of a parameterised number of channels (four by default). Software steers every channel with a single write-only command word. The word holds one 2-bit command per channel, so one write can clear, mask or unmask any mix of channels at once. Each channel drives a level interrupt equal to its request ANDed with its mask. Both bits of every channel are also presented on a status bus for readout.

A channel's completion is signalled in a separate source clock domain as a "done" level. The block turns the rising edge of that level into a one-cycle pulse in the source domain. It then carries the pulse across to the register domain with a toggle-based pulse synchroniser, where the pulse sets the channel's request. Each synchroniser reports busy in the source domain while a toggle is still in flight.

Top module: `irq_cmd_ctrl`

## Requirements
- R1: After reset all requests and masks are 0, every interrupt output is 0 and every busy flag is 0.
- R2: Bits 2k+1:2k of the command word are the command for channel k, and a write affects no other channel. Code 0 does nothing, 1 clears the request, 2 disables the channel and 3 enables it.
- R3: A code whose upper bit is set (2 or 3) loads its lower bit into the channel's mask. Codes 0 and 1 leave the mask unchanged.
- R4: A request is sticky. Once set, it stays set until code 1 is written to its channel or reset is applied. Codes 0, 2 and 3 do not clear it.
- R5: When a completion pulse and a clear command reach a channel's request on the same register clock edge, the request ends up set.
- R6: Each interrupt output is the level request AND mask. Disabling a channel keeps its pending request, which drives the output again once the channel is re-enabled.
- R7: Each rising edge of a source "done" level sets the request exactly once, however long the level stays high.
- R8: In the status bus, bit 2k is the request of channel k and bit 2k+1 is its mask.
- R9: A channel's busy flag is high in the source domain from the clock after a completion edge until the crossing has been acknowledged, and it returns to 0 afterwards.
- R10: The command data has no effect while the write strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| regClk | input | 1 | Register-domain clock |
| regRst | input | 1 | Synchronous reset, register domain, active high |
| srcClk | input | 1 | Source-domain clock |
| srcRst | input | 1 | Synchronous reset, source domain, active high |
| cmdWe | input | 1 | Command word write strobe (one register-clock cycle) |
| cmdData | input | 2*NUM_CH | Command word, one 2-bit code per channel |
| srcDone | input | NUM_CH | Per-channel completion level in the source domain |
| irqOut | output | NUM_CH | Level interrupt per channel (request AND mask) |
| statusBits | output | 2*NUM_CH | Per channel {mask, request} pair |
| srcBusy | output | NUM_CH | Crossing in flight per channel, source domain |

## Verification
The assertions assume that a channel's "done" level is high for at least one source clock and then low for at least one before it rises again. They also assume that a new completion edge arrives only when that channel's busy flag is low, so that no toggle is lost in the crossing and no two pulses come out back to back. The stimulus holds every "done" pulse for several source cycles. It also waits twenty register cycles after each event before the next one, which leaves every crossing idle. A sweep moves a clear command across the arrival cycle of a pulse, so that one offset lands on the same edge as the set.

// File: rtl/irq_cmd_pkg.sv
package irq_cmd_pkg;

  typedef enum logic [1:0] {
    CMD_NOP   = 2'd0,
    CMD_CLEAR = 2'd1,
    CMD_OFF   = 2'd2,
    CMD_ON    = 2'd3
  } irqCmd_e;

  // strobes from control to datapath, one set per channel
  typedef struct packed {
    logic clrReq;
    logic maskWr;
    logic maskVal;
  } chStrobe_t;

endpackage

// File: rtl/irq_pulse_xing.sv
module irq_pulse_xing #(
  parameter int SYNC_STAGES = 2
) (
  input  logic srcClk,
  input  logic srcRst,
  input  logic srcLevel,
  input  logic dstClk,
  input  logic dstRst,
  output logic dstPulse,
  output logic srcBusy
);
  logic srcLevelQ;
  logic srcEdge;
  logic srcTgl;
  logic [SYNC_STAGES:0]   dstSync;
  logic [SYNC_STAGES-1:0] ackSync;

  assign srcEdge = srcLevel & ~srcLevelQ;

  always_ff @(posedge srcClk) begin
    if (srcRst) begin
      srcLevelQ <= 1'b0;
      srcTgl    <= 1'b0;
      ackSync   <= '0;
    end else begin
      srcLevelQ <= srcLevel;
      srcTgl    <= srcTgl ^ srcEdge;
      ackSync   <= {ackSync[SYNC_STAGES-2:0], dstSync[SYNC_STAGES]};
    end
  end

  always_ff @(posedge dstClk) begin
    if (dstRst) dstSync <= '0;
    else        dstSync <= {dstSync[SYNC_STAGES-1:0], srcTgl};
  end

  assign dstPulse = dstSync[SYNC_STAGES-1] ^ dstSync[SYNC_STAGES];
  assign srcBusy  = srcTgl ^ ackSync[SYNC_STAGES-1];

  // R9: an edge on an idle crossing makes it busy
  assert_busy_on_edge_R9: assert property (@(posedge srcClk) disable iff (srcRst)
    (srcEdge && !srcBusy) |=> srcBusy);

  // R7: an isolated event yields a single-cycle pulse
  assert_single_pulse_R7: assert property (@(posedge dstClk) disable iff (dstRst)
    dstPulse |=> !dstPulse);

endmodule

// File: rtl/irq_cmd_control.sv
module irq_cmd_control
  import irq_cmd_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int CMD_W = 2 * NUM_CH
) (
  input  logic                   cmdWe,
  input  logic [CMD_W-1:0]       cmdData,
  output chStrobe_t [NUM_CH-1:0] strobes
);
  for (genvar k = 0; k < NUM_CH; k++) begin : g_dec
    irqCmd_e code;
    assign code = irqCmd_e'(cmdData[2*k +: 2]);
    always_comb begin
      strobes[k] = '0;
      if (cmdWe) begin
        unique case (code)
          CMD_CLEAR: strobes[k].clrReq = 1'b1;
          CMD_OFF:   begin strobes[k].maskWr = 1'b1; strobes[k].maskVal = 1'b0; end
          CMD_ON:    begin strobes[k].maskWr = 1'b1; strobes[k].maskVal = 1'b1; end
          default:   strobes[k] = '0;
        endcase
      end
    end
    // R2: a channel never sees a clear and a mask write from one command
    always_comb assert_one_action_R2: assert (!(strobes[k].clrReq && strobes[k].maskWr));
  end
endmodule

// File: rtl/irq_cmd_datapath.sv
module irq_cmd_datapath
  import irq_cmd_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  chStrobe_t [NUM_CH-1:0] strobes,
  input  logic [NUM_CH-1:0]      evtPulse,
  output logic [NUM_CH-1:0]      reqQ,
  output logic [NUM_CH-1:0]      maskQ,
  output logic [NUM_CH-1:0]      irqOut
);
  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) begin
        reqQ[k]  <= 1'b0;
        maskQ[k] <= 1'b0;
      end else begin
        if (evtPulse[k])            reqQ[k] <= 1'b1;
        else if (strobes[k].clrReq) reqQ[k] <= 1'b0;
        if (strobes[k].maskWr)      maskQ[k] <= strobes[k].maskVal;
      end
    end

    // R4: only a clear drops a pending request
    assert_req_sticky_R4: assert property (@(posedge clk) disable iff (rst)
      (reqQ[k] && !strobes[k].clrReq) |=> reqQ[k]);
    // R5: completion wins over a same-cycle clear
    assert_event_wins_R5: assert property (@(posedge clk) disable iff (rst)
      evtPulse[k] |=> reqQ[k]);
    // R3: mask moves only on a mask write
    assert_mask_hold_R3: assert property (@(posedge clk) disable iff (rst)
      !strobes[k].maskWr |=> $stable(maskQ[k]));
  end

  assign irqOut = reqQ & maskQ;
endmodule

// File: rtl/irq_cmd_ctrl.sv
module irq_cmd_ctrl
  import irq_cmd_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int SYNC_STAGES = 2,
  localparam int CMD_W = 2 * NUM_CH
) (
  input  logic              regClk,
  input  logic              regRst,
  input  logic              srcClk,
  input  logic              srcRst,
  input  logic              cmdWe,
  input  logic [CMD_W-1:0]  cmdData,
  input  logic [NUM_CH-1:0] srcDone,
  output logic [NUM_CH-1:0] irqOut,
  output logic [CMD_W-1:0]  statusBits,
  output logic [NUM_CH-1:0] srcBusy
);
  chStrobe_t [NUM_CH-1:0] strobes;
  logic [NUM_CH-1:0] evtPulse;
  logic [NUM_CH-1:0] reqQ;
  logic [NUM_CH-1:0] maskQ;

  irq_cmd_control #(.NUM_CH(NUM_CH)) ctrl_i (
    .cmdWe   (cmdWe),
    .cmdData (cmdData),
    .strobes (strobes)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_xing
    irq_pulse_xing #(.SYNC_STAGES(SYNC_STAGES)) xing_i (
      .srcClk   (srcClk),
      .srcRst   (srcRst),
      .srcLevel (srcDone[k]),
      .dstClk   (regClk),
      .dstRst   (regRst),
      .dstPulse (evtPulse[k]),
      .srcBusy  (srcBusy[k])
    );
    assign statusBits[2*k]   = reqQ[k];
    assign statusBits[2*k+1] = maskQ[k];
  end

  irq_cmd_datapath #(.NUM_CH(NUM_CH)) dp_i (
    .clk      (regClk),
    .rst      (regRst),
    .strobes  (strobes),
    .evtPulse (evtPulse),
    .reqQ     (reqQ),
    .maskQ    (maskQ),
    .irqOut   (irqOut)
  );

  // R10: no write strobe, no mask change
  assert_idle_bus_R10: assert property (@(posedge regClk) disable iff (regRst)
    !cmdWe |=> $stable(maskQ));
  // R6: an interrupt needs both a request and an enable
  assert_irq_gated_R6: assert property (@(posedge regClk) disable iff (regRst)
    (irqOut & ~(reqQ & maskQ)) == '0);

endmodule

// File: tb/irq_cmd_ctrl_tb_top.sv
module irq_cmd_ctrl_tb_top;
  localparam int N = 4;

  logic regClk = 0, srcClk = 0;
  logic regRst = 1, srcRst = 1;
  logic cmdWe = 0;
  logic [2*N-1:0] cmdData = '0;
  logic [N-1:0] srcDone = '0;
  logic [N-1:0] irqOut;
  logic [2*N-1:0] statusBits;
  logic [N-1:0] srcBusy;

  always #2   regClk = ~regClk;   // 250 MHz
  always #3.5 srcClk = ~srcClk;   // unrelated source clock

  irq_cmd_ctrl #(.NUM_CH(N)) dut_i (
    .regClk, .regRst, .srcClk, .srcRst, .cmdWe, .cmdData,
    .srcDone, .irqOut, .statusBits, .srcBusy
  );

  int nChecks = 0, nFail = 0;
  bit finished = 0;
  logic [N-1:0] mReq = '0, mMask = '0;

  logic [2*N-1:0] expSt[$];
  logic [N-1:0]   expIrq[$];
  string          expTag[$];
  event pushEv;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [2*N-1:0] packStatus();
    logic [2*N-1:0] s;
    for (int k = 0; k < N; k++) begin
      s[2*k]   = mReq[k];
      s[2*k+1] = mMask[k];
    end
    return s;
  endfunction

  // scoreboard monitor
  initial forever begin
    @(pushEv);
    while (expSt.size() > 0) begin
      logic [2*N-1:0] st;
      logic [N-1:0] ir;
      string tg;
      st = expSt.pop_front();
      ir = expIrq.pop_front();
      tg = expTag.pop_front();
      chk(statusBits == st, {tg, " R8 status"}, 32'(statusBits), 32'(st));
      chk(irqOut == ir, {tg, " R6 irq"}, 32'(irqOut), 32'(ir));
    end
  end

  task automatic checkpoint(input string tag);
    expSt.push_back(packStatus());
    expIrq.push_back(mReq & mMask);
    expTag.push_back(tag);
    -> pushEv;
    @(negedge regClk);
  endtask

  task automatic sendCmd(input logic [2*N-1:0] cmd);
    @(negedge regClk);
    cmdWe = 1; cmdData = cmd;
    @(negedge regClk);
    cmdWe = 0;
    for (int k = 0; k < N; k++) begin
      logic [1:0] c;
      c = cmd[2*k +: 2];
      if (c == 2'd1) mReq[k] = 1'b0;
      if (c[1])      mMask[k] = c[0];
    end
  endtask

  task automatic fireEvent(input logic [N-1:0] ch);
    @(negedge srcClk); srcDone = srcDone | ch;
    repeat (3) @(negedge srcClk);
    srcDone = srcDone & ~ch;
    repeat (20) @(negedge regClk);
    mReq = mReq | ch;
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1;
      nFail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge regClk);
    regRst = 0; srcRst = 0;
    @(negedge regClk);
    checkpoint("R1 reset");
    chk(srcBusy == '0, "R1 busy", 32'(srcBusy), 0);

    sendCmd(8'hFF); checkpoint("R3 enable all");
    fireEvent(4'b0100); checkpoint("R7 event ch2");
    sendCmd(8'h20); checkpoint("R6 disable ch2 keeps req");
    chk(irqOut[2] == 1'b0, "R6 masked", 32'(irqOut), 0);
    sendCmd(8'h00); checkpoint("R2 nop");
    sendCmd(8'h30); checkpoint("R6 re-enable shows req");
    chk(irqOut[2] == 1'b1, "R6 re-enabled", 32'(irqOut[2]), 1);

    @(negedge regClk); cmdData = 8'h55;
    repeat (5) @(negedge regClk);
    cmdData = 8'hAA;
    repeat (5) @(negedge regClk);
    checkpoint("R10 data without strobe");

    sendCmd(8'h10); checkpoint("R4 clear ch2");
    fireEvent(4'b1001); checkpoint("R7 events ch0 ch3");
    sendCmd(8'hA8); checkpoint("R4 codes 0/2 keep req");
    sendCmd(8'h39); checkpoint("R2 mixed codes per field");

    // R7: a level held high sets once; clear afterwards stays clear
    sendCmd(8'hFF);
    @(negedge srcClk); srcDone[1] = 1'b1;
    @(negedge srcClk);
    chk(srcBusy[1] == 1'b1, "R9 busy after edge", 32'(srcBusy[1]), 1);
    repeat (20) @(negedge regClk);
    chk(srcBusy[1] == 1'b0, "R9 busy returns low", 32'(srcBusy[1]), 0);
    mReq[1] = 1'b1;
    checkpoint("R7 held level set");
    sendCmd(8'h04);
    repeat (30) @(negedge regClk);
    checkpoint("R7 held level no second set");
    @(negedge srcClk); srcDone[1] = 1'b0;
    repeat (20) @(negedge regClk);
    checkpoint("R7 falling edge no event");

    // R5: sweep a clear across the arrival of a completion pulse
    for (int d = 0; d < 10; d++) begin
      logic pre;
      sendCmd(8'h01);
      @(negedge srcClk); srcDone[0] = 1'b1;
      repeat (d) @(negedge regClk);
      @(negedge regClk);
      pre = irqOut[0];
      cmdWe = 1; cmdData = 8'h01;
      @(negedge regClk);
      cmdWe = 0;
      repeat (20) @(negedge regClk);
      chk(irqOut[0] == !pre, "R5 completion vs clear", 32'(irqOut[0]), 32'(!pre));
      mReq[0] = !pre;
      @(negedge srcClk); srcDone[0] = 1'b0;
      repeat (20) @(negedge regClk);
      checkpoint("R5 sweep state");
    end

    // R1: reset in mid-run
    @(negedge regClk); regRst = 1; srcRst = 1;
    repeat (3) @(negedge regClk);
    regRst = 0; srcRst = 0;
    mReq = '0; mMask = '0;
    @(negedge regClk);
    checkpoint("R1 mid-run reset");
    chk(srcBusy == '0, "R1 busy after reset", 32'(srcBusy), 0);

    repeat (2) @(negedge regClk);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end
endmodule